// File: doc/BRIEF.md
# Parity-Banked Split-Half Register File

This block stores 128 registers of 64 bits. Each register is cut into a low and a high 32-bit half, and the halves are kept in four separate 32-bit banks. A bank holds only one half of registers with one parity: even low, even high, odd low or odd high. A register number and a half therefore pick exactly one bank, and the row inside that bank is the register number with its lowest bit removed.

Each bank has its own read port and its own write port, so all four banks can be read and written in the same cycle. Port `b` of each group always serves bank `b`, because operand routing sits outside this block. A request whose register parity does not belong to the port's bank is dropped. Every write carries a 4-bit byte mask, so an 8-bit or 16-bit element update touches only its own bytes and needs no earlier read. A read returns its data one cycle later, together with a registered valid flag.

Top module: `rf_oehl_top`

## Requirements
- R1: While reset is held and right after it is released, every `rd_valid` bit is 0 and every `rd_data` lane is 0.
- R2: A read accepted on port `b` in one cycle raises `rd_valid[b]` in the next cycle with the data. A cycle with no accepted read on port `b` leaves `rd_valid[b]` low in the next cycle.
- R3: Port `b` serves bank `b`, where bank = {register bit 0, half}. Half 0 is bits 31:0 and half 1 is bits 63:32. So port 0 serves even/low, port 1 even/high, port 2 odd/low and port 3 odd/high. The bank row is register number >> 1.
- R4: A read or write on port `b` whose register bit 0 differs from bit 1 of `b` is ignored. The read gives no valid and the write changes no stored bit.
- R5: On a write, byte lane `i` (bits 8i+7:8i of the half) is updated only when `wr_be[b][i]` is 1. The other bytes keep their old value.
- R6: A read and a write to the same bank row in the same cycle return the data held before the write.
- R7: A write with an all-zero byte mask changes nothing.
- R8: The four banks work independently. Writes on all four ports in one cycle all take effect.
- R9: `rd_data[b]` holds its last value in every cycle after one with no accepted read on port `b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 4 | Read request, one bit per bank port |
| rd_reg | input | 4x7 | Register number for each read port |
| rd_data | output | 4x32 | Registered read data for each bank |
| rd_valid | output | 4 | Read data valid, one cycle after an accepted read |
| wr_en | input | 4 | Write request, one bit per bank port |
| wr_reg | input | 4x7 | Register number for each write port |
| wr_be | input | 4x4 | Byte write mask for each write port |
| wr_data | input | 4x32 | Write data for each bank port |

## Verification
The hardest case to reach is a read and a write landing on the same bank row in one cycle while other banks are busy too. At the ports this looks the same as a plain read unless the new data differs from the old. The bench first fills every row with a known pattern. It then drives a read and a partial-mask write at one register in the same cycle, with values chosen so that an early merge shows up. A follow-up read confirms that the write did land. Mismatched-parity requests are read back through the correctly matched port, so a stray write would be seen.

// File: rtl/rf_oehl_pkg.sv
package rf_oehl_pkg;
  localparam int BYTE_W = 8;

  // Bank index from register parity and half select.
  function automatic logic [1:0] bank_of(input logic odd, input logic hi);
    return {odd, hi};
  endfunction

  // True when a request's parity belongs to the given bank.
  function automatic logic parity_fits(input logic odd, input logic [1:0] bank);
    return odd == bank[1];
  endfunction
endpackage

// File: rtl/rf_oehl_gate.sv
module rf_oehl_gate #(
  parameter int           RN_W     = 7,
  parameter logic [1:0]   BANK_IDX = 2'd0,
  localparam int          ROW_W    = RN_W - 1
) (
  input  logic            req,
  input  logic [RN_W-1:0] rn,
  output logic            hit,
  output logic [ROW_W-1:0] row
);
  import rf_oehl_pkg::*;

  logic [1:0] target;

  always_comb begin
    target = bank_of(rn[0], BANK_IDX[0]);
    hit    = req && parity_fits(rn[0], BANK_IDX) && (target == BANK_IDX);
    row    = rn[RN_W-1:1];
  end
endmodule

// File: rtl/rf_oehl_bank.sv
module rf_oehl_bank #(
  parameter int  ROWS  = 64,
  parameter int  WIDTH = 32,
  localparam int ROW_W = $clog2(ROWS),
  localparam int BE_W  = WIDTH / rf_oehl_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_acc,
  input  logic [ROW_W-1:0] rd_row,
  input  logic             wr_acc,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  import rf_oehl_pkg::*;

  logic [WIDTH-1:0] mem [ROWS];

  // Byte-strobed storage; no read is needed to merge partial writes.
  always_ff @(posedge clk) begin
    for (int i = 0; i < BE_W; i++) begin
      if (wr_acc && wr_be[i]) begin
        mem[wr_row][i*BYTE_W +: BYTE_W] <= wr_data[i*BYTE_W +: BYTE_W];
      end
    end
  end

  // Output register samples the array before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= mem[rd_row];
    end
  end

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(rd_data));
endmodule

// File: rtl/rf_oehl_top.sv
module rf_oehl_top #(
  parameter int  NUM_REGS  = 128,
  parameter int  HALF_BITS = 32,
  localparam int NUM_BANKS = 4,
  localparam int RN_W      = $clog2(NUM_REGS),
  localparam int ROWS      = NUM_REGS / 2,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int BE_W      = HALF_BITS / rf_oehl_pkg::BYTE_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_BANKS-1:0]                 rd_en,
  input  logic [NUM_BANKS-1:0][RN_W-1:0]       rd_reg,
  output logic [NUM_BANKS-1:0][HALF_BITS-1:0]  rd_data,
  output logic [NUM_BANKS-1:0]                 rd_valid,
  input  logic [NUM_BANKS-1:0]                 wr_en,
  input  logic [NUM_BANKS-1:0][RN_W-1:0]       wr_reg,
  input  logic [NUM_BANKS-1:0][BE_W-1:0]       wr_be,
  input  logic [NUM_BANKS-1:0][HALF_BITS-1:0]  wr_data
);
  // Named internal events for the checks below.
  logic [NUM_BANKS-1:0]            rd_hit;
  logic [NUM_BANKS-1:0]            wr_hit;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rd_row;
  logic [NUM_BANKS-1:0][ROW_W-1:0] wr_row;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rf_oehl_gate #(.RN_W(RN_W), .BANK_IDX(2'(b))) rd_gate_i (
      .req (rd_en[b]),
      .rn  (rd_reg[b]),
      .hit (rd_hit[b]),
      .row (rd_row[b])
    );

    rf_oehl_gate #(.RN_W(RN_W), .BANK_IDX(2'(b))) wr_gate_i (
      .req (wr_en[b]),
      .rn  (wr_reg[b]),
      .hit (wr_hit[b]),
      .row (wr_row[b])
    );

    rf_oehl_bank #(.ROWS(ROWS), .WIDTH(HALF_BITS)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_acc   (rd_hit[b]),
      .rd_row   (rd_row[b]),
      .wr_acc   (wr_hit[b]),
      .wr_row   (wr_row[b]),
      .wr_be    (wr_be[b]),
      .wr_data  (wr_data[b]),
      .rd_data  (rd_data[b]),
      .rd_valid (rd_valid[b])
    );

    // R4
    wrong_parity_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[b] && (rd_reg[b][0] != 1'(b >> 1))) |=> !rd_valid[b]);
    // R2
    valid_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[b] |-> $past(rd_en[b]));
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (rd_valid == '0));
endmodule

// File: tb/rf_oehl_top_tb_top.sv
module rf_oehl_top_tb_top;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       rd_en = '0;
  logic [3:0][6:0]  rd_reg = '0;
  logic [3:0][31:0] rd_data;
  logic [3:0]       rd_valid;
  logic [3:0]       wr_en = '0;
  logic [3:0][6:0]  wr_reg = '0;
  logic [3:0][3:0]  wr_be = '0;
  logic [3:0][31:0] wr_data = '0;

  int errors = 0;
  int checks = 0;
  logic [63:0] model [128];
  logic [3:0][31:0] prev_d = '0;

  always #4 clk = ~clk;

  rf_oehl_top dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_reg(rd_reg),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_be(wr_be), .wr_data(wr_data)
  );

  localparam logic [6:0]  TV_REG [8] = '{7'd0, 7'd1, 7'd2, 7'd63, 7'd64, 7'd101, 7'd126, 7'd127};
  localparam logic [63:0] TV_DAT [8] = '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                                         64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_FFFF_FFFF,
                                         64'hFFFF_FFFF_0000_0000, 64'hA5A5_5A5A_3C3C_C3C3,
                                         64'h1111_2222_3333_4444, 64'h8000_0001_7FFF_FFFE};

  task automatic check(input string tag, input int b, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %0d %s got %h expected %h", tag, b, what, got, exp);
    end
  endtask

  // Apply prepared inputs for one edge and check both read outputs.
  task automatic tick(input string tag);
    logic [3:0][31:0] exp_d;
    logic [3:0]       exp_v;
    for (int b = 0; b < 4; b++) begin
      exp_v[b] = rd_en[b] && (rd_reg[b][0] == 1'(b / 2));
      exp_d[b] = exp_v[b] ? model[rd_reg[b]][(b % 2) * 32 +: 32] : prev_d[b];
    end
    for (int b = 0; b < 4; b++) begin
      if (wr_en[b] && (wr_reg[b][0] == 1'(b / 2))) begin
        for (int i = 0; i < 4; i++) begin
          if (wr_be[b][i]) model[wr_reg[b]][(b % 2) * 32 + i * 8 +: 8] = wr_data[b][i*8 +: 8];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      check(tag, b, 32'(rd_valid[b]), 32'(exp_v[b]), "valid");
      check(tag, b, rd_data[b], exp_d[b], "data");
    end
    prev_d = exp_d;
    rd_en = '0; wr_en = '0; wr_be = '0;
  endtask

  task automatic put(input int b, input logic [6:0] r, input logic [3:0] be, input logic [31:0] d);
    wr_en[b] = 1'b1; wr_reg[b] = r; wr_be[b] = be; wr_data[b] = d;
  endtask

  task automatic get(input int b, input logic [6:0] r);
    rd_en[b] = 1'b1; rd_reg[b] = r;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 128; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after release
    for (int b = 0; b < 4; b++) begin
      check("R1", b, 32'(rd_valid[b]), 32'd0, "valid");
      check("R1", b, rd_data[b], 32'd0, "data");
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 4; b++) check("R1", b, 32'(rd_valid[b]), 32'd0, "valid after release");

    // R8: fill every row of all four banks in the same cycles
    for (int row = 0; row < 64; row++) begin
      for (int b = 0; b < 4; b++) put(b, 7'(row * 2 + b / 2), 4'hF, 32'(row * 16 + b) ^ 32'h5A00_0000);
      tick("R8");
    end

    // R3: table of 64-bit values, written as two halves, read back by half
    for (int i = 0; i < 8; i++) begin
      put(TV_REG[i][0] * 2,     TV_REG[i], 4'hF, TV_DAT[i][31:0]);
      put(TV_REG[i][0] * 2 + 1, TV_REG[i], 4'hF, TV_DAT[i][63:32]);
      tick("R3");
      get(TV_REG[i][0] * 2,     TV_REG[i]);
      get(TV_REG[i][0] * 2 + 1, TV_REG[i]);
      tick("R3");
      checks++;
      if ({rd_data[TV_REG[i][0] * 2 + 1], rd_data[TV_REG[i][0] * 2]} !== TV_DAT[i]) begin
        errors++;
        $display("FAIL R3 reg %0d got %h expected %h", TV_REG[i],
                 {rd_data[TV_REG[i][0] * 2 + 1], rd_data[TV_REG[i][0] * 2]}, TV_DAT[i]);
      end
    end

    // R5: mask 0101 on reg 4 low half touches bytes 0 and 2 only
    put(0, 7'd4, 4'b0101, 32'hAABB_CCDD);
    tick("R5");
    get(0, 7'd4);
    tick("R5");

    // R7: empty mask on reg 6 high half leaves it alone
    put(1, 7'd6, 4'b0000, 32'hFFFF_FFFF);
    tick("R7");
    get(1, 7'd6);
    tick("R7");

    // R4: odd register on an even-bank port is dropped, then read via port 2
    put(0, 7'd9, 4'hF, 32'h0BAD_0BAD);
    get(1, 7'd9);
    tick("R4");
    get(2, 7'd9);
    tick("R4");
    get(0, 7'd8);
    tick("R4");

    // R6: read and partial write of the same row in one cycle
    put(3, 7'd11, 4'b1001, 32'h7700_0077);
    get(3, 7'd11);
    tick("R6");
    get(3, 7'd11);
    tick("R6");

    // R9: idle cycle, data must hold
    tick("R9");
    tick("R9");

    // R2: read on all four ports at once, different registers
    get(0, 7'd20); get(1, 7'd40); get(2, 7'd21); get(3, 7'd127);
    tick("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule